// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block sits between a processor core and an external asynchronous memory bus. It takes byte or word read and write requests from the core and runs them as cycles on the bus, one phase per clock. A sub-cycle has a set order: an address phase (T1), a programmable number of wait states, a strobe phase (T2), an optional burst beat, a closing phase (T3) and a programmable number of hold clocks. The bus can be set to 8 or 16 bits wide. On an 8-bit bus a word request becomes two byte sub-cycles, or a single burst read when bursting is enabled.

The request side is a valid/ready channel. The core holds `req_valid` and the request fields stable until a clock edge where `req_ready` is also high, and the request is taken at that edge. `req_ready` is high only while the sequencer is idle, so it stays low for the whole of a request, including all split or burst sub-cycles. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` holds the read result until the next request is accepted. The configuration inputs are plain levels. They must stay stable while a request is in progress.

Writes use an early-strobe timing when `cfg_early_wr` is set, so the memory needs no read strobe to tell a write from a read. When a read is accepted directly after an early write, one idle bus clock is placed between the two cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: `req_ready` is 1 out of reset and whenever the sequencer is idle, and 0 from the cycle after acceptance until the acknowledge. `rsp_valid` pulses for exactly one cycle per request. The pulse comes in the clock after the final T3, or after the final hold clock when holds are configured. Out of reset, `bus_cs_n`=1, `bus_rd_n`=1, `bus_wr_n`=2'b11 and `bus_doe`=0.
- R2: The phases of a sub-cycle run in this order, one clock each: T1, then `cfg_waits` wait clocks, then T2, then (burst only) one burst beat, then T3. `bus_cs_n` is low only in wait, T2 and burst clocks. For reads, `bus_rd_n` is low in exactly those clocks.
- R3: With `cfg_early_wr`=1, a write's enabled strobes (`bus_wr_n`, active low) are low from T1 through T3 and high from the following clock. `bus_rd_n` stays 1. A write with no waits or holds takes three bus clocks.
- R4: Write data is driven (`bus_doe`=1) from the first clock after T1 through the last hold clock, or through T3 when there are no holds. It is released in the next clock, and `bus_doe` is 0 in T1.
- R5: `bus_addr` carries the sub-cycle address from T1 through the last hold clock and is 0 when the bus is idle.
- R6: `cfg_hold` hold clocks follow T3. The strobes are inactive during them.
- R7: On a 16-bit bus, a byte at an even address uses `bus_wr_n[0]` and D0-7, and a byte at an odd address uses `bus_wr_n[1]` and D8-15. A word uses both strobes and D0-15, at the even address, in one sub-cycle.
- R8: On an 8-bit bus only `bus_wr_n[0]` and D0-7 are used. A word write always runs as two sub-cycles: the even address with the low byte first, then the odd address with the high byte. This holds even when `cfg_burst`=1.
- R9: A word read on an 8-bit bus with `cfg_burst`=1 runs as T1, T2, burst beat, T3. The address is even in T2 and odd in the burst beat. The low result byte is taken in T2 and the high byte in the burst beat.
- R10: A word read on an 8-bit bus with `cfg_burst`=0 runs as two separate sub-cycles, with chip select deasserted between them. The first reads the even address into the low byte and the second reads the odd address into the high byte.
- R11: A read accepted in the acknowledge cycle of an early write is preceded by one idle bus clock, in which `bus_addr`=0 and all strobes are inactive. No idle clock is added after a write made with `cfg_early_wr`=0.
- R12: With `cfg_early_wr`=0, the write strobes are low only in the clocks where `bus_cs_n` is low.
- R13: A byte read returns the selected byte zero-extended in `rsp_rdata[7:0]`. A word read on a 16-bit bus returns D0-15 as sampled in T2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | AW | Byte address (bit 0 ignored for words) |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 16 | Read result |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_burst | input | 1 | Allow burst word reads on the 8-bit bus |
| cfg_early_wr | input | 1 | Early-strobe write timing |
| cfg_waits | input | WW | Wait clocks per sub-cycle |
| cfg_hold | input | HW | Hold clocks after T3 |
| bus_addr | output | AW | External address |
| bus_dout | output | 16 | Data driven to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Data read from the bus |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Byte write strobes, active low |
| bus_cs_n | output | 1 | Chip select, active low |

## Verification
A wrong phase register shows up in the same clock on `bus_cs_n`, `bus_wr_n` or `bus_doe`, because each strobe is decoded straight from the phase. A miscounted wait or hold register moves the acknowledge by whole clocks, and this shows in the first request that uses that count. Errors in the split-part flag or the early-write flag change the sub-cycle address or add or drop the idle clock within one request. Lane or capture faults appear as wrong byte placement on `bus_dout` or in `rsp_rdata` at the acknowledge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_T1,
    PH_WAIT,
    PH_T2,
    PH_TB,
    PH_T3,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/ebs_phase_fsm.sv
module ebs_phase_fsm
  import ebs_pkg::*;
#(
  parameter int WW = 3,
  parameter int HW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          gap,
  input  logic          burst,
  input  logic [WW-1:0] cfg_waits,
  input  logic [HW-1:0] cfg_hold,
  output phase_t        phase,
  output logic          done
);
  localparam int CW = (WW > HW) ? WW : HW;

  logic [CW-1:0] cnt;
  phase_t        after_done;

  assign done = (phase == PH_T3 && cfg_hold == '0) ||
                (phase == PH_HOLD && cnt == '0);
  assign after_done = start ? (gap ? PH_GAP : PH_T1) : PH_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) phase <= gap ? PH_GAP : PH_T1;
        PH_GAP:  phase <= PH_T1;
        PH_T1: begin
          if (cfg_waits != '0) begin
            phase <= PH_WAIT;
            cnt   <= CW'(cfg_waits) - CW'(1);
          end else begin
            phase <= PH_T2;
          end
        end
        PH_WAIT: begin
          if (cnt == '0) phase <= PH_T2;
          else           cnt   <= cnt - CW'(1);
        end
        PH_T2:   phase <= burst ? PH_TB : PH_T3;
        PH_TB:   phase <= PH_T3;
        PH_T3: begin
          if (cfg_hold != '0) begin
            phase <= PH_HOLD;
            cnt   <= CW'(cfg_hold) - CW'(1);
          end else begin
            phase <= after_done;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) phase <= after_done;
          else           cnt   <= cnt - CW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_T2_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2) |-> ($past(phase) == PH_T1 || $past(phase) == PH_WAIT)); // R2
  AST_T3_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T3) |-> ($past(phase) == PH_T2 || $past(phase) == PH_TB)); // R2
  AST_HOLD_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> $past(phase) == PH_T3); // R6
endmodule

// File: rtl/ebs_lane.sv
module ebs_lane
  import ebs_pkg::*;
(
  input  logic          bus16,
  input  logic          word,
  input  logic          odd,
  input  logic          hi_part,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  output logic [1:0]    lane_en,
  output logic [DW-1:0] dout,
  output logic [7:0]    rd_byte
);
  always_comb begin
    if (!bus16) begin
      lane_en = 2'b01;
      dout    = {8'h00, hi_part ? wdata[15:8] : wdata[7:0]};
      rd_byte = din[7:0];
    end else if (word) begin
      lane_en = 2'b11;
      dout    = wdata;
      rd_byte = din[7:0];
    end else if (odd) begin
      lane_en = 2'b10;
      dout    = {wdata[7:0], 8'h00};
      rd_byte = din[15:8];
    end else begin
      lane_en = 2'b01;
      dout    = {8'h00, wdata[7:0]};
      rd_byte = din[7:0];
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 3,
  parameter int HW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  input  logic          cfg_bus16,
  input  logic          cfg_burst,
  input  logic          cfg_early_wr,
  input  logic [WW-1:0] cfg_waits,
  input  logic [HW-1:0] cfg_hold,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  output logic          bus_rd_n,
  output logic [1:0]    bus_wr_n,
  output logic          bus_cs_n
);
  phase_t        phase;
  logic          done, start, gap, accept, more;
  logic [AW-1:0] c_addr, sub_addr;
  logic          c_wr, c_word, c_split, c_burst, part, last_ew;
  logic [15:0]   c_wdata, rdata_q;
  logic          cs_act, wr_win, hi_sel, on_bus;
  logic [1:0]    lane_en;
  logic [7:0]    rd_byte;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign more      = c_split && !part;
  assign start     = accept || (done && more);
  assign gap       = accept && !req_write && last_ew;

  ebs_phase_fsm #(.WW(WW), .HW(HW)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start), .gap(gap), .burst(c_burst),
    .cfg_waits(cfg_waits), .cfg_hold(cfg_hold), .phase(phase), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr <= '0; c_wr <= 1'b0; c_word <= 1'b0; c_wdata <= '0;
      c_split <= 1'b0; c_burst <= 1'b0; part <= 1'b0;
      rdata_q <= '0; rsp_valid <= 1'b0; last_ew <= 1'b0;
    end else begin
      rsp_valid <= done && !more;
      if (done)                   last_ew <= c_wr && cfg_early_wr;
      else if (phase == PH_IDLE)  last_ew <= 1'b0;
      if (accept) begin
        c_addr  <= req_addr;
        c_wr    <= req_write;
        c_word  <= req_word;
        c_wdata <= req_wdata;
        c_split <= req_word && !cfg_bus16 && (req_write || !cfg_burst);
        c_burst <= req_word && !cfg_bus16 && !req_write && cfg_burst;
        part    <= 1'b0;
        rdata_q <= '0;
      end else begin
        if (done && more) part <= 1'b1;
        if (!c_wr && (phase == PH_T2 || phase == PH_TB)) begin
          if (cfg_bus16 && c_word) rdata_q <= bus_din;
          else if (c_word && hi_sel) rdata_q[15:8] <= rd_byte;
          else if (c_word) rdata_q[7:0] <= rd_byte;
          else rdata_q <= {8'h00, rd_byte};
        end
      end
    end
  end

  assign hi_sel = part || (phase == PH_TB);
  always_comb begin
    sub_addr = c_addr;
    if (c_word) sub_addr[0] = hi_sel;
  end

  ebs_lane u_lane (
    .bus16(cfg_bus16), .word(c_word), .odd(sub_addr[0]), .hi_part(hi_sel),
    .wdata(c_wdata), .din(bus_din), .lane_en(lane_en), .dout(bus_dout),
    .rd_byte(rd_byte)
  );

  assign on_bus   = !(phase inside {PH_IDLE, PH_GAP});
  assign cs_act   = phase inside {PH_WAIT, PH_T2, PH_TB};
  assign wr_win   = cfg_early_wr ? (phase inside {PH_T1, PH_WAIT, PH_T2, PH_T3}) : cs_act;
  assign bus_addr = on_bus ? sub_addr : '0;
  assign bus_cs_n = !cs_act;
  assign bus_rd_n = !(cs_act && !c_wr);
  assign bus_wr_n = ~(lane_en & {2{wr_win && c_wr}});
  assign bus_doe  = c_wr && (phase inside {PH_WAIT, PH_T2, PH_T3, PH_HOLD});
  assign rsp_rdata = rdata_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R1
  AST_CS_AFTER_T1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $past(phase) == PH_T1); // R2
  AST_WR_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_n != 2'b11) |-> bus_rd_n); // R3
  AST_DOE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_doe) |-> ($past(phase) == PH_T3 || $past(phase) == PH_HOLD)); // R4
  AST_BUS8_WR1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bus16 |-> bus_wr_n[1]); // R8
  AST_BURST_READ8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TB) |-> (!c_wr && c_word && !cfg_bus16)); // R9
  AST_GAP_AFTER_EW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |-> $past(last_ew)); // R11
endmodule

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic req_ready, rsp_valid;
  logic [15:0] req_addr = 0, req_wdata = 0, rsp_rdata;
  logic cfg_bus16 = 1, cfg_burst = 0, cfg_early_wr = 1;
  logic [2:0] cfg_waits = 0;
  logic [1:0] cfg_hold = 0;
  logic [15:0] bus_addr, bus_dout, bus_din;
  logic bus_doe, bus_rd_n, bus_cs_n;
  logic [1:0] bus_wr_n;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem8(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_din = cfg_bus16 ? {mem8({bus_addr[15:1], 1'b1}), mem8({bus_addr[15:1], 1'b0})}
                             : {8'h00, mem8(bus_addr)};

  ext_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_bus16(cfg_bus16), .cfg_burst(cfg_burst), .cfg_early_wr(cfg_early_wr),
    .cfg_waits(cfg_waits), .cfg_hold(cfg_hold), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n)
  );

  typedef struct packed {
    logic cs; logic rd; logic [1:0] wr; logic oe; logic rdy;
    logic [15:0] ad; logic [15:0] dq;
  } snap_t;
  snap_t sn [0:31];
  int    n_ack;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // Drives a request at the current negedge and records bus pins per clock until the acknowledge
  task automatic do_req(input logic wr, input logic wd, input logic [15:0] a, input logic [15:0] d);
    req_valid = 1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    chk("R1", "ready before request", req_ready, 1);
    @(posedge clk);
    n_ack = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      req_valid = 0;
      sn[i] = '{bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, req_ready, bus_addr, bus_dout};
      if (rsp_valid) begin n_ack = i; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1", "ready", req_ready, 1);
    chk("R1", "cs_n", bus_cs_n, 1);
    chk("R1", "rd_n", bus_rd_n, 1);
    chk("R1", "wr_n", bus_wr_n, 2'b11);
    chk("R1", "doe", bus_doe, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_early_byte_odd();
    cfg_bus16 = 1; cfg_early_wr = 1; cfg_waits = 0; cfg_hold = 0;
    do_req(1, 0, 16'h0013, 16'h00C7);
    chk("R3", "ack clocks", n_ack, 3);
    chk("R3", "T1 wr_n", sn[0].wr, 2'b01);
    chk("R3", "T1 cs_n", sn[0].cs, 1);
    chk("R4", "T1 doe", sn[0].oe, 0);
    chk("R3", "T1 rd_n", sn[0].rd, 1);
    chk("R5", "T1 addr", sn[0].ad, 16'h0013);
    chk("R2", "T2 cs_n", sn[1].cs, 0);
    chk("R7", "T2 odd lane", sn[1].dq[15:8], 8'hC7);
    chk("R1", "busy ready", sn[1].rdy, 0);
    chk("R3", "T3 cs_n", sn[2].cs, 1);
    chk("R3", "T3 wr_n", sn[2].wr, 2'b01);
    chk("R4", "T3 doe", sn[2].oe, 1);
    chk("R3", "after wr_n", sn[3].wr, 2'b11);
    chk("R4", "after doe", sn[3].oe, 0);
    @(negedge clk);
    chk("R1", "single ack", rsp_valid, 0);
  endtask

  task automatic t_waits_hold();
    cfg_bus16 = 1; cfg_early_wr = 1; cfg_waits = 2; cfg_hold = 1;
    do_req(1, 1, 16'h0040, 16'hBEEF);
    chk("R6", "ack clocks", n_ack, 6);
    chk("R7", "T1 word strobes", sn[0].wr, 2'b00);
    chk("R2", "T1 cs_n", sn[0].cs, 1);
    chk("R2", "wait cs_n", sn[1].cs, 0);
    chk("R4", "wait data", {sn[1].oe, sn[1].dq}, {1'b1, 16'hBEEF});
    chk("R2", "T2 cs_n", sn[3].cs, 0);
    chk("R2", "T3 cs_n", sn[4].cs, 1);
    chk("R3", "T3 wr_n", sn[4].wr, 2'b00);
    chk("R6", "hold wr_n", sn[5].wr, 2'b11);
    chk("R4", "hold doe", sn[5].oe, 1);
    chk("R5", "hold addr", sn[5].ad, 16'h0040);
    chk("R4", "release doe", sn[6].oe, 0);
    chk("R5", "idle addr", sn[6].ad, 16'h0000);
    cfg_waits = 0; cfg_hold = 0;
    idle(2);
  endtask

  task automatic t_word_write8();
    cfg_bus16 = 0; cfg_burst = 1; cfg_early_wr = 1;
    do_req(1, 1, 16'h0020, 16'h1234);
    chk("R8", "ack clocks", n_ack, 6);
    chk("R8", "first addr", sn[0].ad, 16'h0020);
    chk("R8", "first wr_n", sn[0].wr, 2'b10);
    chk("R8", "low byte", sn[1].dq[7:0], 8'h34);
    chk("R8", "cs_n between", sn[2].cs, 1);
    chk("R8", "second addr", sn[3].ad, 16'h0021);
    chk("R4", "second T1 doe", sn[3].oe, 0);
    chk("R8", "high byte", sn[4].dq[7:0], 8'h12);
    idle(2);
  endtask

  task automatic t_burst_read();
    cfg_bus16 = 0; cfg_burst = 1;
    do_req(0, 1, 16'h0030, 16'h0000);
    chk("R9", "ack clocks", n_ack, 4);
    chk("R9", "T2 strobes", {sn[1].cs, sn[1].rd, sn[1].ad}, {2'b00, 16'h0030});
    chk("R9", "beat strobes", {sn[2].cs, sn[2].rd, sn[2].ad}, {2'b00, 16'h0031});
    chk("R9", "T3 cs_n", sn[3].cs, 1);
    chk("R9", "read no wr", sn[1].wr, 2'b11);
    chk("R9", "rdata", rsp_rdata, {mem8(16'h0031), mem8(16'h0030)});
    idle(2);
  endtask

  task automatic t_split_read();
    cfg_bus16 = 0; cfg_burst = 0;
    do_req(0, 1, 16'h0030, 16'h0000);
    chk("R10", "ack clocks", n_ack, 6);
    chk("R10", "cs_n gap", {sn[2].cs, sn[3].cs}, 2'b11);
    chk("R10", "second addr", sn[4].ad, 16'h0031);
    chk("R10", "rdata", rsp_rdata, {mem8(16'h0031), mem8(16'h0030)});
    idle(2);
  endtask

  task automatic t_gap_read();
    cfg_bus16 = 1; cfg_early_wr = 1;
    do_req(1, 0, 16'h0050, 16'h0011);
    do_req(0, 0, 16'h0051, 16'h0000);
    chk("R11", "ack clocks", n_ack, 4);
    chk("R11", "idle clock", {sn[0].cs, sn[0].rd, sn[0].wr, sn[0].ad}, {4'b1111, 16'h0000});
    chk("R11", "T1 addr", sn[1].ad, 16'h0051);
    chk("R2", "read strobes", {sn[2].cs, sn[2].rd}, 2'b00);
    chk("R13", "byte rdata", rsp_rdata, {8'h00, mem8(16'h0051)});
    idle(2);
  endtask

  task automatic t_normal_write();
    cfg_bus16 = 1; cfg_early_wr = 0;
    do_req(1, 0, 16'h0060, 16'h00A5);
    chk("R12", "ack clocks", n_ack, 3);
    chk("R12", "T1 wr_n", sn[0].wr, 2'b11);
    chk("R12", "T2 wr_n", {sn[1].cs, sn[1].wr}, 3'b010);
    chk("R7", "even lane", sn[1].dq[7:0], 8'hA5);
    chk("R12", "T3 wr_n", sn[2].wr, 2'b11);
    do_req(0, 1, 16'h0062, 16'h0000);
    chk("R11", "no idle clock", n_ack, 3);
    chk("R13", "word rdata", rsp_rdata, {mem8(16'h0063), mem8(16'h0062)});
    cfg_early_wr = 1;
    idle(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_early_byte_odd();
    idle(2);
    t_waits_hold();
    t_word_write8();
    t_burst_read();
    t_split_read();
    t_gap_read();
    t_normal_write();
    summary();
    $finish;
  end
endmodule